// File: doc/BRIEF.md
# Packed Color Palette Store with Change Tracking

This block holds a 64-entry color palette. Each entry is written over a 16-bit word port carrying three 4-bit color channels. Only the upper three bits of each channel are kept, and they are stored packed into a 9-bit field with the channel order reversed. A read on the same port returns the entry unpacked back into the bus layout, with every dropped bit reading as zero.

Alongside the storage, the block tracks which palette entries a renderer must refresh. A write that really alters an entry marks it dirty and raises a global "something changed" flag. Entries whose index has a zero low nibble are never marked by writes. A separate border flag rises when the entry selected by the border index input changes, or when that index input itself moves to a new value. A flush pulse clears every flag once the consumer has caught up. Reset raises all of them, so the first frame repaints the whole palette.

Top module: `palette_ram`

## Requirements
- R1: A write stores `wr_data & 16'h0EEE`. From the next cycle on, `rd_data` at that address returns exactly that value, with bits 15:12, 8, 4 and 0 reading as zero.
- R2: The entry index is `addr[6:1]`, giving 64 independent entries. `addr[0]` has no effect on which entry is read or written.
- R3: A write whose masked value differs from the stored entry, to an index whose bits 3:0 are not all zero, sets `dirty[index]` and `any_dirty` on the next cycle.
- R4: A changing write to an index whose bits 3:0 are zero (0, 16, 32, 48) stores the value but sets no dirty bit and leaves `any_dirty` unchanged.
- R5: A write whose masked value equals the stored entry changes nothing: no dirty bit, no `any_dirty` and no `border_dirty`.
- R6: A changing write to the index equal to `border_idx` sets `border_dirty` on the next cycle, including when that index has a zero low nibble.
- R7: A change of `border_idx` from the value it held in the previous cycle sets `border_dirty`. Holding it steady does not set the flag again.
- R8: A `flush` cycle with no new change clears all of `dirty`, `any_dirty` and `border_dirty` on the next cycle.
- R9: After reset, every entry reads zero and all 64 `dirty` bits, `any_dirty` and `border_dirty` are 1.
- R10: When a flush and a change fall in the same cycle, the change wins. Its dirty bit (or border flag) stays set and every other flag is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 7 | Byte address of the word; bits 6:1 select the entry |
| wr_en | input | 1 | Write strobe for `wr_data` at `addr` |
| wr_data | input | 16 | Color word in bus layout |
| rd_data | output | 16 | Unpacked color of the entry at `addr` |
| border_idx | input | 6 | Index of the palette entry used as border color |
| flush | input | 1 | Clears all change flags |
| dirty | output | 64 | Per-entry changed flags |
| any_dirty | output | 1 | Set when any entry has been marked since the last flush |
| border_dirty | output | 1 | Set when the border color may have changed |

## Verification
The flush pulse and a new change can land on the same clock edge. The bench provokes this in two ways: it asserts `flush` together with a value-changing write to an eligible entry, and separately together with a move of `border_idx`. After the edge it requires the whole `dirty` vector to hold only the written entry's bit, with `any_dirty` or `border_dirty` still set. Losing the change or keeping a stale flag both show up as a mismatch on the full 64-bit vector.

// File: rtl/pal_pkg.sv
// Package: palette geometry and the bus <-> packed color conversions.
// Assumes three channels of four bus bits each, low bit of each dropped.
package pal_pkg;
    localparam int CH_N     = 3;                 // color channels per word
    localparam int NIB_W    = 4;                 // bus bits per channel
    localparam int CH_BITS  = NIB_W - 1;         // kept bits per channel
    localparam int WORD_W   = 16;                // bus word width
    localparam int PACK_W   = CH_N * CH_BITS;    // stored bits per entry
    localparam int IDX_W    = 6;                 // entry index width
    localparam int ENTRIES  = 1 << IDX_W;        // palette depth

    // Bus layout -> packed: bus channel c (from the top) lands in slot c.
    function automatic logic [PACK_W-1:0] pack_color(input logic [WORD_W-1:0] w);
        logic [PACK_W-1:0] p;
        p = '0;
        for (int c = 0; c < CH_N; c++)
            p[c*CH_BITS +: CH_BITS] = w[(CH_N-1-c)*NIB_W+1 +: CH_BITS];
        return p;
    endfunction

    // Packed -> bus layout; every dropped bus bit returns as zero.
    function automatic logic [WORD_W-1:0] unpack_color(input logic [PACK_W-1:0] p);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int c = 0; c < CH_N; c++)
            w[(CH_N-1-c)*NIB_W+1 +: CH_BITS] = p[c*CH_BITS +: CH_BITS];
        return w;
    endfunction
endpackage

// File: rtl/pal_store.sv
// Module: pal_store
// Holds the packed palette entries and flags writes that alter an entry.
// Assumes a single write port; the read path is combinational on rd_idx.
module pal_store
    import pal_pkg::*;
#(
    parameter int N_ENT = ENTRIES,
    parameter int IW    = IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [IW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic              changed
);
    logic [PACK_W-1:0] mem_q [N_ENT];
    logic [PACK_W-1:0] packed_in;

    // Pack the incoming word and compare it with the stored entry.
    always_comb begin
        packed_in = pack_color(wr_word);
        changed   = wr_en && (packed_in != mem_q[wr_idx]);
    end

    // Entry storage: zero on reset, updated only when the value changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) mem_q[i] <= '0;
        end else if (changed) begin
            mem_q[wr_idx] <= packed_in;
        end
    end

    // Read path: unpack the addressed entry back to bus layout.
    always_comb rd_word = unpack_color(mem_q[rd_idx]);

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_idx)] == $past(packed_in)));  // R1
    AST_MASKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word & ~16'h0EEE) == '0);  // R1
endmodule

// File: rtl/pal_flags.sv
// Module: pal_flags
// Keeps per-entry dirty bits, the global changed flag and the border flag.
// Assumes 'mark' is high only for writes that altered an entry; a new
// change in the same cycle as a flush takes priority over the clear.
module pal_flags #(
    parameter int N_ENT     = 64,
    parameter int IW        = 6,
    parameter int SKIP_BITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mark,
    input  logic [IW-1:0]    mark_idx,
    input  logic [IW-1:0]    border_idx,
    input  logic             flush,
    output logic [N_ENT-1:0] dirty,
    output logic             any_dirty,
    output logic             border_dirty
);
    logic          eligible;
    logic          border_hit;
    logic          border_move;
    logic [IW-1:0] border_seen_q;
    logic          any_q;
    logic          border_q;

    // Decode which change events this cycle carries.
    always_comb begin
        eligible    = mark && (mark_idx[SKIP_BITS-1:0] != '0);
        border_hit  = mark && (mark_idx == border_idx);
        border_move = (border_idx != border_seen_q);
    end

    // One dirty bit per entry: set on an eligible change, else cleared by flush.
    for (genvar e = 0; e < N_ENT; e++) begin : g_dirty
        always_ff @(posedge clk) begin
            if (!rst_n)                                     dirty[e] <= 1'b1;
            else if (eligible && (mark_idx == IW'(e)))      dirty[e] <= 1'b1;
            else if (flush)                                 dirty[e] <= 1'b0;
        end
    end

    // Global changed flag follows the same set/clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        any_q <= 1'b1;
        else if (eligible) any_q <= 1'b1;
        else if (flush)    any_q <= 1'b0;
    end

    // Border flag: raised by a write to the border entry or a new index.
    always_ff @(posedge clk) begin
        if (!rst_n)                          border_q <= 1'b1;
        else if (border_hit || border_move)  border_q <= 1'b1;
        else if (flush)                      border_q <= 1'b0;
    end

    // Remember last cycle's border index to detect moves.
    always_ff @(posedge clk) begin
        if (!rst_n) border_seen_q <= '0;
        else        border_seen_q <= border_idx;
    end

    assign any_dirty    = any_q;
    assign border_dirty = border_q;

    AST_MARK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        eligible |=> (dirty[$past(mark_idx)] && any_dirty));  // R3
    AST_ANY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        any_dirty == (|dirty));  // R3
    AST_SKIP_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!eligible && !flush) |=> (dirty == $past(dirty)));  // R4
    AST_BORDER_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (border_hit || border_move) |=> border_dirty);  // R6
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !mark && !border_move) |=> (dirty == '0 && !any_dirty && !border_dirty));  // R8
endmodule

// File: rtl/palette_ram.sv
// Module: palette_ram (top)
// 64-entry packed color palette with per-entry and border change tracking.
// Assumes word accesses: addr[0] is ignored, addr[6:1] selects the entry.
module palette_ram
    import pal_pkg::*;
#(
    parameter int ADDR_W = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [WORD_W-1:0]    rd_data,
    input  logic [ADDR_W-2:0]    border_idx,
    input  logic                 flush,
    output logic [(1<<(ADDR_W-1))-1:0] dirty,
    output logic                 any_dirty,
    output logic                 border_dirty
);
    localparam int IW    = ADDR_W - 1;
    localparam int N_ENT = 1 << IW;

    logic [IW-1:0] idx;
    logic          chg;
    logic          unused_addr_lsb;

    // Word index from the byte address; the byte select bit is dropped.
    always_comb begin
        idx             = addr[ADDR_W-1:1];
        unused_addr_lsb = addr[0];
    end

    pal_store #(.N_ENT(N_ENT), .IW(IW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_word (wr_data),
        .rd_idx  (idx),
        .rd_word (rd_data),
        .changed (chg)
    );

    pal_flags #(.N_ENT(N_ENT), .IW(IW), .SKIP_BITS(4)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .mark         (chg),
        .mark_idx     (idx),
        .border_idx   (border_idx),
        .flush        (flush),
        .dirty        (dirty),
        .any_dirty    (any_dirty),
        .border_dirty (border_dirty)
    );

    AST_SAME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !chg && !flush) |=> (dirty == $past(dirty)));  // R5
    AST_RESET_FLAGS: assert property (@(posedge clk)
        !rst_n |=> (&dirty && any_dirty && border_dirty));  // R9
    AST_FLUSH_VS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && chg && idx[3:0] != 4'd0) |=> (dirty == (N_ENT'(1) << $past(idx))));  // R10
endmodule

// File: tb/palette_ram_test.sv
module palette_ram_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [5:0]  border_idx = 6'd5;
    logic        flush = 1'b0;
    logic [63:0] dirty;
    logic        any_dirty;
    logic        border_dirty;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    palette_ram uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .border_idx(border_idx),
        .flush(flush), .dirty(dirty), .any_dirty(any_dirty),
        .border_dirty(border_dirty)
    );

    // Stimulus table: address, written word (border_idx held at 5).
    localparam int NV = 8;
    localparam logic [6:0]  VA [NV] = '{7'h02, 7'h03, 7'h20, 7'h7E,
                                        7'h40, 7'h14, 7'h7F, 7'h00};
    localparam logic [15:0] VD [NV] = '{16'hFFFF, 16'h1234, 16'h0ABC, 16'h0E00,
                                        16'h00E0, 16'h000E, 16'h00E0, 16'h0222};

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] a, input logic [15:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        tick();
        flush = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick();
        // R9: reset state while reset is held
        check("R9 dirty", dirty, {64{1'b1}});
        check("R9 any", 64'(any_dirty), 64'd1);
        check("R9 border", 64'(border_dirty), 64'd1);
        addr = 7'h2A; #1;
        check("R9 read zero", 64'(rd_data), 64'd0);
        rst_n = 1'b1;
        tick();
        // R8: flush clears everything
        do_flush();
        check("R8 dirty", dirty, 64'd0);
        check("R8 any", 64'(any_dirty), 64'd0);
        check("R8 border", 64'(border_dirty), 64'd0);

        // Table walk: R1 readback, R2 indexing, R3/R4 dirty marking
        for (int i = 0; i < NV; i++) begin
            logic [5:0]  ix;
            logic        elig;
            do_flush();
            do_write(VA[i], VD[i]);
            ix   = VA[i][6:1];
            elig = (ix[3:0] != 4'd0);
            check("R1 R2 readback", 64'(rd_data), 64'(VD[i] & 16'h0EEE));
            check(elig ? "R3 dirty" : "R4 dirty", dirty, elig ? (64'd1 << ix) : 64'd0);
            check(elig ? "R3 any" : "R4 any", 64'(any_dirty), 64'(elig));
            check("R6 no border", 64'(border_dirty), 64'd0);
        end

        // R2: addr[0] does not change which entry is read
        addr = 7'h03; #1;
        check("R2 lsb ignored", 64'(rd_data), 64'h0224);

        // R5: same masked value -> nothing flagged (border points at entry 1)
        border_idx = 6'd1;
        tick();
        do_flush();
        do_write(7'h02, 16'h0225);
        check("R5 dirty", dirty, 64'd0);
        check("R5 any", 64'(any_dirty), 64'd0);
        check("R5 border", 64'(border_dirty), 64'd0);

        // R6: changing write to the border entry
        do_write(7'h02, 16'h0000);
        check("R6 border", 64'(border_dirty), 64'd1);
        check("R3 dirty1", dirty, 64'd2);

        // R6 + R4: border entry with zero low nibble (index 0)
        border_idx = 6'd0;
        tick();
        do_flush();
        do_write(7'h00, 16'h0EEE);
        check("R6 border idx0", 64'(border_dirty), 64'd1);
        check("R4 any idx0", 64'(any_dirty), 64'd0);
        check("R1 idx0 read", 64'(rd_data), 64'h0EEE);

        // R7: moving the border index raises the flag, holding it does not
        do_flush();
        border_idx = 6'd9;
        tick();
        check("R7 move", 64'(border_dirty), 64'd1);
        do_flush();
        tick();
        check("R7 steady", 64'(border_dirty), 64'd0);

        // R10: flush and changing write in the same cycle
        do_write(7'h14, 16'h0000);   // leaves entry 10 dirty beforehand
        flush = 1'b1;
        do_write(7'h04, 16'h0888);
        flush = 1'b0;
        check("R10 dirty", dirty, 64'd4);
        check("R10 any", 64'(any_dirty), 64'd1);

        // R10: flush and border move in the same cycle
        do_flush();
        flush = 1'b1; border_idx = 6'd12;
        tick();
        flush = 1'b0;
        check("R10 border", 64'(border_dirty), 64'd1);
        check("R10 dirty clr", dirty, 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule